// File: doc/BRIEF.md
# Clock-Compensating Elastic Buffer

This block moves received symbols, each an 8-bit character with a data/control flag, from the recovered receive clock into the local core clock. The two clocks run at nearly the same rate but not exactly. The buffer therefore steers its own fill level towards half of its depth. On the write side it discards a skip symbol when the buffer holds too much. On the read side it repeats a skip symbol when the buffer holds too little. Every other symbol passes through in order. Writes that find the buffer full and reads that find it empty are flagged.

The write side runs the two-state machine `WR_ARMED` / `WR_HELD`. Transition *discard*: `WR_ARMED` to `WR_HELD` when a skip symbol is dropped. Transition *rearm*: `WR_HELD` to `WR_ARMED` when a skip symbol is stored. The read side runs `RD_PRIME` / `RD_RUN` / `RD_HOLD`. Transition *start*: `RD_PRIME` to `RD_RUN` once the read-side occupancy reaches half depth. Transition *repeat*: `RD_RUN` to `RD_HOLD` when a skip symbol is emitted without popping. Transition *release*: `RD_HOLD` to `RD_RUN` when a skip symbol is popped. Each side sees the other side's pointer as a gray-coded value passed through two flops. Each side forms its own occupancy from that value.

Top module: `elastic_skp_buf`

## Requirements
- R1: Symbols that are not skip symbols leave the read port in the order they were written, with the flag and character unchanged, and none is lost or repeated unless an overflow drops it.
- R2: A skip symbol is exactly flag=1 with character 0x1C. Character 0x1C with flag=0, and control characters other than 0x1C, are never discarded or repeated.
- R3: With the write side armed, a skip symbol that arrives while the write-side occupancy exceeds DEPTH/2 is discarded and the write side disarms. The next skip symbol that arrives is stored and rearms it. At most one skip symbol is discarded per adjustment.
- R4: When the read side is in `RD_RUN`, the read-side occupancy is nonzero and below DEPTH/2, and the head entry is a skip symbol, the read side emits a skip symbol without popping and enters `RD_HOLD`. Popping the next skip symbol returns it to `RD_RUN`.
- R5: After read reset, `rd_valid` stays low until the read-side occupancy has first reached DEPTH/2.
- R6: A write that would be stored while the write side counts DEPTH entries is dropped and sets `wr_overflow`. The flag stays set until write reset.
- R7: Once started, a read cycle that finds the buffer empty drives `rd_valid` low and sets `rd_underflow`. The flag stays set until read reset.
- R8: During and straight after reset, `rd_valid`, `wr_overflow` and `rd_underflow` are low.
- R9: With a continuous stream that carries a skip symbol every fourth position and clocks that differ by about 5 %, neither overflow nor underflow occurs. The number of skip symbols falls when the writer is faster and rises when the reader is faster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | recovered receive clock |
| wr_rst_n | input | 1 | asynchronous active-low reset, write side |
| wr_valid | input | 1 | a symbol is offered this cycle |
| wr_ctrl | input | 1 | data/control flag of the offered symbol (1 = control) |
| wr_data | input | 8 | character of the offered symbol |
| wr_overflow | output | 1 | sticky: a symbol was dropped because the buffer was full |
| rd_clk | input | 1 | local core clock |
| rd_rst_n | input | 1 | asynchronous active-low reset, read side |
| rd_valid | output | 1 | `rd_ctrl`/`rd_data` carry a symbol this cycle |
| rd_ctrl | output | 1 | data/control flag of the output symbol |
| rd_data | output | 8 | character of the output symbol |
| rd_underflow | output | 1 | sticky: the read side found the buffer empty |

## Verification
The first pattern is a short burst with the read clock free-running. It separates the priming hold from normal draining and from the first underflow. The second pattern fills the buffer with the read clock stopped, then sends three skip symbols in a row. Its exact output sequence shows discard, rearm, the second discard and the repeated skip symbol at the drain, and it shows that 0x1C data and other control characters survive. The third pattern writes one symbol past full. The last two are long streams with the writer and then the reader running faster. They compare skip counts in and out and show that only skip symbols change.

// File: rtl/esb_pkg.sv
package esb_pkg;

    localparam int unsigned CHAR_W = 8;
    localparam logic [CHAR_W-1:0] SKIP_CHAR = 8'h1C;

    typedef struct packed {
        logic              ctrl;
        logic [CHAR_W-1:0] char;
    } sym_t;

    typedef enum logic [0:0] {
        WR_ARMED = 1'b0,
        WR_HELD  = 1'b1
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_PRIME = 2'd0,
        RD_RUN   = 2'd1,
        RD_HOLD  = 2'd2
    } rd_state_t;

    function automatic logic sym_is_skip(input sym_t s);
        return s.ctrl && (s.char == SKIP_CHAR);
    endfunction

endpackage

// File: rtl/esb_ptr_sync.sv
// Two-flop crossing of a gray pointer, converted to binary in the receiving domain.
module esb_ptr_sync #(
    parameter int unsigned PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit folds in all gray bits above it.
    always_comb begin
        bin_out[PW-1] = sync_q[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ sync_q[i];
        end
    end
endmodule

// File: rtl/esb_store.sv
// Register-file storage: written in the write domain, read asynchronously by address.
module esb_store
    import esb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sym_t          wsym,
    input  logic [AW-1:0] raddr,
    output sym_t          rsym
);
    sym_t cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= wsym;
        end
    end

    assign rsym = cells[raddr];
endmodule

// File: rtl/esb_wr_ctrl.sv
// Write side: stores symbols, discards skip symbols above half fill, flags overflow.
module esb_wr_ctrl
    import esb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  sym_t          in_sym,
    input  logic [PW-1:0] rbin_sync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          overflow
);
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);

    wr_state_t     st_q, st_d;
    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wgray_q;
    logic          ovf_q;
    logic [PW-1:0] occ;
    logic          full;
    logic          skip_in;
    logic          do_write;
    logic          do_discard;
    logic          ovf_hit;
    logic [PW-1:0] wbin_nxt;

    assign occ     = wbin_q - rbin_sync;
    assign full    = (occ == FULL_LVL);
    assign skip_in = sym_is_skip(in_sym);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WR_ARMED;
        else        st_q <= st_d;
    end

    // next state and decisions
    always_comb begin
        st_d       = st_q;
        do_write   = 1'b0;
        do_discard = 1'b0;
        ovf_hit    = 1'b0;
        if (in_valid) begin
            unique case (st_q)
                WR_ARMED: begin
                    if (skip_in && (occ > HALF_LVL)) begin
                        do_discard = 1'b1;
                        st_d       = WR_HELD;
                    end else if (full) begin
                        ovf_hit = 1'b1;
                    end else begin
                        do_write = 1'b1;
                    end
                end
                WR_HELD: begin
                    if (full) begin
                        ovf_hit = 1'b1;
                    end else begin
                        do_write = 1'b1;
                        if (skip_in) st_d = WR_ARMED;
                    end
                end
            endcase
        end
    end

    assign wbin_nxt = wbin_q + PW'(do_write);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            wbin_q  <= wbin_nxt;
            wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
            ovf_q   <= ovf_q | ovf_hit;
        end
    end

    assign we       = do_write;
    assign waddr    = wbin_q[AW-1:0];
    assign wgray    = wgray_q;
    assign overflow = ovf_q;

    p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_LVL);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (wbin_q == $past(wbin_q)));
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    p_discard_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && skip_in && st_q == WR_ARMED && occ > HALF_LVL)
            |=> (st_q == WR_HELD && $stable(wbin_q)));
endmodule

// File: rtl/esb_rd_ctrl.sv
// Read side: primes to half fill, pops symbols, repeats skip symbols below half fill.
module esb_rd_ctrl
    import esb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wbin_sync,
    input  sym_t          head,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          out_valid,
    output sym_t          out_sym,
    output logic          underflow
);
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);
    localparam sym_t SKIP_SYM = '{ctrl: 1'b1, char: SKIP_CHAR};

    rd_state_t     st_q, st_d;
    logic [PW-1:0] rbin_q;
    logic [PW-1:0] rgray_q;
    logic          valid_q;
    sym_t          sym_q;
    logic          uf_q;
    logic [PW-1:0] occ;
    logic          head_skip;
    logic          pop;
    logic          emit;
    sym_t          emit_sym;
    logic          uf_hit;
    logic [PW-1:0] rbin_nxt;

    assign occ       = wbin_sync - rbin_q;
    assign head_skip = sym_is_skip(head);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RD_PRIME;
        else        st_q <= st_d;
    end

    // next state and decisions
    always_comb begin
        st_d     = st_q;
        pop      = 1'b0;
        emit     = 1'b0;
        emit_sym = head;
        uf_hit   = 1'b0;
        unique case (st_q)
            RD_PRIME: begin
                if (occ >= HALF_LVL) st_d = RD_RUN;
            end
            RD_RUN, RD_HOLD: begin
                if (occ == '0) begin
                    uf_hit = 1'b1;
                end else if (st_q == RD_RUN && occ < HALF_LVL && head_skip) begin
                    emit     = 1'b1;
                    emit_sym = SKIP_SYM;
                    st_d     = RD_HOLD;
                end else begin
                    pop  = 1'b1;
                    emit = 1'b1;
                    if (st_q == RD_HOLD && head_skip) st_d = RD_RUN;
                end
            end
            default: st_d = RD_PRIME;
        endcase
    end

    assign rbin_nxt = rbin_q + PW'(pop);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            valid_q <= 1'b0;
            sym_q   <= '0;
            uf_q    <= 1'b0;
        end else begin
            rbin_q  <= rbin_nxt;
            rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
            valid_q <= emit;
            sym_q   <= emit_sym;
            uf_q    <= uf_q | uf_hit;
        end
    end

    assign raddr     = rbin_q[AW-1:0];
    assign rgray     = rgray_q;
    assign out_valid = valid_q;
    assign out_sym   = sym_q;
    assign underflow = uf_q;

    p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_LVL);
    p_uf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uf_q |=> uf_q);
    p_empty_no_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |=> $stable(rbin_q));
    p_prime_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RD_PRIME) |=> !valid_q);
    p_repeat_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RD_HOLD && $past(st_q) == RD_RUN)
            |-> (valid_q && sym_is_skip(sym_q) && $stable(rbin_q)));
endmodule

// File: rtl/elastic_skp_buf.sv
module elastic_skp_buf
    import esb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic              wr_ctrl,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              wr_overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic              rd_valid,
    output logic              rd_ctrl,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_underflow
);
    sym_t          in_sym;
    sym_t          head_sym;
    sym_t          out_sym;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wbin_in_rd;
    logic [PW-1:0] rbin_in_wr;

    assign in_sym = '{ctrl: wr_ctrl, char: wr_data};

    esb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .in_valid (wr_valid),
        .in_sym   (in_sym),
        .rbin_sync(rbin_in_wr),
        .we       (we),
        .waddr    (waddr),
        .wgray    (wgray),
        .overflow (wr_overflow)
    );

    esb_store #(.DEPTH(DEPTH)) u_store (
        .wr_clk(wr_clk),
        .we    (we),
        .waddr (waddr),
        .wsym  (in_sym),
        .raddr (raddr),
        .rsym  (head_sym)
    );

    esb_ptr_sync #(.PW(PW)) u_w2r (
        .clk    (rd_clk),
        .rst_n  (rd_rst_n),
        .gray_in(wgray),
        .bin_out(wbin_in_rd)
    );

    esb_ptr_sync #(.PW(PW)) u_r2w (
        .clk    (wr_clk),
        .rst_n  (wr_rst_n),
        .gray_in(rgray),
        .bin_out(rbin_in_wr)
    );

    esb_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .wbin_sync(wbin_in_rd),
        .head     (head_sym),
        .raddr    (raddr),
        .rgray    (rgray),
        .out_valid(rd_valid),
        .out_sym  (out_sym),
        .underflow(rd_underflow)
    );

    assign rd_ctrl = out_sym.ctrl;
    assign rd_data = out_sym.char;
endmodule

// File: tb/elastic_skp_buf_tb.sv
`timescale 1ns/100ps
module elastic_skp_buf_tb;
    localparam real CLK_PERIOD = 10.0;
    localparam int  STREAM_LEN = 400;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0;
    logic       rd_rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_overflow;
    logic       rd_valid;
    logic       rd_ctrl;
    logic [7:0] rd_data;
    logic       rd_underflow;

    real rd_half = CLK_PERIOD / 2.0;
    bit  rd_run  = 1'b1;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  loose   = 1'b0;
    int  got_cnt = 0;
    int  skp_in  = 0;
    int  skp_out = 0;
    logic [8:0] exp_q[$];

    elastic_skp_buf u_dut (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .wr_valid    (wr_valid),
        .wr_ctrl     (wr_ctrl),
        .wr_data     (wr_data),
        .wr_overflow (wr_overflow),
        .rd_clk      (rd_clk),
        .rd_rst_n    (rd_rst_n),
        .rd_valid    (rd_valid),
        .rd_ctrl     (rd_ctrl),
        .rd_data     (rd_data),
        .rd_underflow(rd_underflow)
    );

    always #(CLK_PERIOD / 2.0) wr_clk = ~wr_clk;
    always begin
        #(rd_half);
        if (rd_run) rd_clk = ~rd_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as the design emits symbols
    always @(negedge rd_clk) begin
        if (rd_rst_n && rd_valid) begin
            got_cnt++;
            if (loose && rd_ctrl && rd_data == 8'h1C) begin
                skp_out++;
            end else if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R1 unexpected symbol: actual=%h expected=none", {rd_ctrl, rd_data});
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({rd_ctrl, rd_data} == e, "R1", "symbol order", {rd_ctrl, rd_data}, e);
            end
        end
    end

    task automatic send(input logic c, input logic [7:0] d, input bit push);
        wr_valid = 1'b1;
        wr_ctrl  = c;
        wr_data  = d;
        if (push) exp_q.push_back({c, d});
        @(negedge wr_clk);
        wr_valid = 1'b0;
    endtask

    task automatic wr_wait(input int n);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic reset_all();
        rd_run = 1'b1;
        @(negedge wr_clk);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        wr_wait(4);
        exp_q.delete();
        got_cnt = 0;
        skp_in  = 0;
        skp_out = 0;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        wr_wait(2);
    endtask

    task automatic rd_stop();
        @(negedge rd_clk);
        rd_run = 1'b0;
    endtask

    task automatic run_stream();
        for (int k = 0; k < STREAM_LEN; k++) begin
            if (k % 4 == 3) begin
                skp_in++;
                send(1'b1, 8'h1C, 1'b0);
            end else if (k % 16 == 1) begin
                send(1'b0, 8'h1C, 1'b1);          // R2: data 0x1C kept
            end else if (k % 16 == 6) begin
                send(1'b1, 8'hBC, 1'b1);          // R2: other control kept
            end else begin
                send(1'b0, 8'((k * 37 + 5) & 8'hFF), 1'b1);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R8: reset state
        wr_wait(2);
        check(rd_valid == 1'b0, "R8", "rd_valid in reset", rd_valid, 0);
        check(wr_overflow == 1'b0, "R8", "wr_overflow in reset", wr_overflow, 0);
        check(rd_underflow == 1'b0, "R8", "rd_underflow in reset", rd_underflow, 0);

        // Test 1: priming hold (R5), then drain and underflow (R7)
        reset_all();
        loose = 1'b0;
        for (int i = 0; i < 5; i++) send(1'b0, 8'h40 + 8'(i), 1'b1);
        wr_wait(30);
        check(got_cnt == 0, "R5", "outputs before half fill", got_cnt, 0);
        check(rd_underflow == 1'b0, "R5", "no underflow while priming", rd_underflow, 0);
        for (int i = 5; i < 8; i++) send(1'b0, 8'h40 + 8'(i), 1'b1);
        wr_wait(40);
        check(got_cnt == 8, "R1", "symbols after priming", got_cnt, 8);
        check(exp_q.size() == 0, "R1", "scoreboard left", exp_q.size(), 0);
        check(rd_underflow == 1'b1, "R7", "underflow after drain", rd_underflow, 1);
        check(rd_valid == 1'b0, "R7", "rd_valid when empty", rd_valid, 0);

        // Test 2: discard, rearm, second discard, repeat at drain (R3, R4, R2)
        reset_all();
        rd_stop();
        for (int i = 0; i < 10; i++) begin
            if (i == 3)      send(1'b0, 8'h1C, 1'b1);
            else if (i == 6) send(1'b1, 8'hBC, 1'b1);
            else             send(1'b0, 8'h80 + 8'(i), 1'b1);
        end
        send(1'b1, 8'h1C, 1'b0);   // discarded, occupancy 10
        send(1'b1, 8'h1C, 1'b1);   // stored, rearms
        send(1'b1, 8'h1C, 1'b0);   // discarded again
        exp_q.push_back({1'b1, 8'h1C});   // repeated copy when drained below half
        wr_wait(4);
        check(wr_overflow == 1'b0, "R3", "no overflow on discard", wr_overflow, 0);
        rd_run = 1'b1;
        wr_wait(60);
        check(got_cnt == 12, "R3", "count with one stored skip plus R4 repeat", got_cnt, 12);
        check(exp_q.size() == 0, "R4", "scoreboard left", exp_q.size(), 0);
        check(rd_underflow == 1'b1, "R7", "underflow after drain", rd_underflow, 1);

        // Test 3: overflow (R6)
        reset_all();
        rd_stop();
        for (int i = 0; i < 16; i++) send(1'b0, 8'h10 + 8'(i), 1'b1);
        check(wr_overflow == 1'b0, "R6", "no overflow at full", wr_overflow, 0);
        send(1'b0, 8'hEE, 1'b0);
        check(wr_overflow == 1'b1, "R6", "overflow on extra write", wr_overflow, 1);
        rd_run = 1'b1;
        wr_wait(60);
        check(got_cnt == 16, "R6", "dropped symbol absent", got_cnt, 16);
        check(exp_q.size() == 0, "R6", "scoreboard left", exp_q.size(), 0);
        check(wr_overflow == 1'b1, "R6", "overflow sticky", wr_overflow, 1);

        // Test 4: writer faster (R9, R3)
        rd_half = CLK_PERIOD * 1.05 / 2.0;
        reset_all();
        loose = 1'b1;
        run_stream();
        check(wr_overflow == 1'b0, "R9", "no overflow, writer faster", wr_overflow, 0);
        check(rd_underflow == 1'b0, "R9", "no underflow during stream", rd_underflow, 0);
        wr_wait(100);
        check(exp_q.size() == 0, "R2", "all non-skip symbols delivered", exp_q.size(), 0);
        check(skp_out < skp_in, "R9", "skip count lowered", skp_out, skp_in);

        // Test 5: reader faster (R9, R4)
        rd_half = CLK_PERIOD * 0.95 / 2.0;
        reset_all();
        loose = 1'b1;
        run_stream();
        check(rd_underflow == 1'b0, "R9", "no underflow, reader faster", rd_underflow, 0);
        check(wr_overflow == 1'b0, "R9", "no overflow during stream", wr_overflow, 0);
        wr_wait(100);
        check(exp_q.size() == 0, "R2", "all non-skip symbols delivered", exp_q.size(), 0);
        check(skp_out > skp_in, "R4", "skip count raised", skp_out, skp_in);
        check(rd_underflow == 1'b1, "R7", "underflow after stream ends", rd_underflow, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule